// File: doc/BRIEF.md
# LED Breathing PWM Generator

This block drives a single LED with a pulse-width-modulated signal whose duty cycle swells and fades on its own, giving a slow "breathing" glow. A sub-counter divides the system clock into PWM periods of `div_cfg + 1` clocks. The output is active while the sub-counter is below the current duty level. The duty level moves by one every `step_cfg + 1` PWM periods. It climbs from `duty_lo` to `duty_hi`, then descends back to `duty_lo`, and the cycle repeats for as long as the block is enabled.

A small sequencer controls the ramp. It has four named states:
- **ST_IDLE** (disabled): all counters are cleared and the duty level is loaded with the minimum.
- **ST_RISE**: the duty level increments at each step event.
- **ST_FALL**: the duty level decrements at each step event.
- **ST_HOLD**: used when the minimum is not below the maximum; the duty stays at the minimum.

The sequencer has these transitions:
- **go_ramp**: ST_IDLE to ST_RISE, on enable when min < max.
- **go_hold**: ST_IDLE to ST_HOLD, on enable when min >= max.
- **peak**: ST_RISE to ST_FALL, at the step event that raises the duty to the maximum.
- **trough**: ST_FALL to ST_RISE, at the step event that lowers the duty to the minimum.
- **stop**: any running state to ST_IDLE, when enable is low at a clock edge.

A polarity input selects whether the active level is high or low.

Configuration inputs are expected to be held steady while the block is enabled. Change them while it is disabled.

Top module: `breath_pwm`

## Requirements
- R1: While `breath_en` is low, and during reset, `pwm_out` sits at its inactive level. That level equals `invert_out`: 0 when `invert_out` = 0, and 1 when `invert_out` = 1.
- R2: When running, the sub-counter counts 0, 1, …, `div_cfg` and then wraps to 0. Each PWM period therefore lasts `div_cfg + 1` clocks. The first clock after the enabling edge has sub-counter value 0.
- R3: Within a period, the output is at its active level exactly while the sub-counter is less than the current duty level. A duty level of `div_cfg + 1` or more keeps the output active for the whole period.
- R4: After enable, the duty level starts at `duty_lo`. It changes only at the end of every (`step_cfg + 1`)-th PWM period.
- R5: With `duty_lo` < `duty_hi`, the duty level rises by exactly 1 per step until it equals `duty_hi`, then falls by 1 per step until it equals `duty_lo`, and this repeats.
- R6: With `duty_lo` >= `duty_hi`, the duty level stays fixed at `duty_lo`.
- R7: `invert_out` = 1 makes the active level low, which inverts the whole waveform. `invert_out` = 0 makes it high.
- R8: Lowering `breath_en` clears both counters at the next edge. A later enable restarts the ramp from `duty_lo` with the sub-counter at 0.
- R9: With `duty_lo` < `duty_hi`, the duty level never leaves the range [`duty_lo`, `duty_hi`].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| breath_en | input | 1 | Runs the breathing ramp while high |
| invert_out | input | 1 | 0: active-high output, 1: active-low output |
| div_cfg | input | LEVEL_W (8) | PWM period length minus one, in clocks |
| step_cfg | input | STEP_W (16) | PWM periods per duty step, minus one |
| duty_hi | input | LEVEL_W (8) | Upper duty level |
| duty_lo | input | LEVEL_W (8) | Lower duty level |
| pwm_out | output | 1 | Breathing PWM output |

## Verification
The following are checked by assertions on every cycle:
- The sub-counter wraps to zero after reaching the divider value and otherwise advances by exactly one.
- Both counters clear one edge after a disable.
- The duty level holds between step events and moves by exactly one at each step in the ramp states.
- The duty level reloads the minimum on entry and in the hold state.
- The output sits at the polarity level one edge after the enable drops.

Only the bench's sweeps can show the overall shape of the waveform. It compares every output sample against a triangle-wave model computed from the cycle count, over a grid of divider, step, minimum, maximum and polarity settings. That comparison confirms that the ramp turns at exactly the maximum and the minimum, that it stays in range, and that it restarts from the minimum after a re-enable.

// File: rtl/breath_pkg.sv
package breath_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RISE = 2'd1,
        ST_FALL = 2'd2,
        ST_HOLD = 2'd3
    } breath_state_t;
endpackage

// File: rtl/breath_timer.sv
// Sub-counter across one PWM period and period counter across one duty step.
module breath_timer #(
    parameter int LEVEL_W = 8,
    parameter int STEP_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic [LEVEL_W-1:0] cfg_div,
    input  logic [STEP_W-1:0]  cfg_step,
    output logic [LEVEL_W-1:0] cnt,
    output logic               step_evt
);
    localparam logic [LEVEL_W-1:0] ONE_L = LEVEL_W'(1);
    localparam logic [STEP_W-1:0]  ONE_S = STEP_W'(1);

    logic [STEP_W-1:0] pcnt;
    logic              wrap;

    assign wrap     = (cnt >= cfg_div);
    assign step_evt = run && wrap && (pcnt >= cfg_step);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            pcnt <= '0;
        end else if (!run) begin
            cnt  <= '0;
            pcnt <= '0;
        end else if (wrap) begin
            cnt <= '0;
            if (pcnt >= cfg_step) pcnt <= '0;
            else                  pcnt <= pcnt + ONE_S;
        end else begin
            cnt <= cnt + ONE_L;
        end
    end

    // R2: the sub-counter returns to zero after reaching the divider value
    p_wrap_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && wrap) |=> (cnt == '0));

    // R2: otherwise the sub-counter advances by exactly one
    p_count_up_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !wrap) |=> (cnt == $past(cnt) + ONE_L));

    // R8: both counters are cleared after a disable
    p_idle_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!run) |=> (cnt == '0 && pcnt == '0));
endmodule

// File: rtl/breath_seq.sv
// Duty-ramp state machine: rises to the maximum, falls to the minimum, or holds.
module breath_seq
    import breath_pkg::*;
#(
    parameter int LEVEL_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               step_evt,
    input  logic [LEVEL_W-1:0] cfg_min,
    input  logic [LEVEL_W-1:0] cfg_max,
    output breath_state_t      state,
    output logic [LEVEL_W-1:0] duty,
    output logic               running
);
    localparam logic [LEVEL_W-1:0] ONE_L = LEVEL_W'(1);

    breath_state_t      nxt_state;
    logic [LEVEL_W-1:0] duty_up;
    logic [LEVEL_W-1:0] duty_dn;

    assign duty_up = duty + ONE_L;
    assign duty_dn = duty - ONE_L;
    assign running = (state != ST_IDLE) && enable;

    // next-state logic
    always_comb begin
        nxt_state = state;
        unique case (state)
            ST_IDLE: begin
                if (enable) nxt_state = (cfg_min >= cfg_max) ? ST_HOLD : ST_RISE;
            end
            ST_RISE: begin
                if (!enable)                               nxt_state = ST_IDLE;
                else if (step_evt && (duty_up >= cfg_max)) nxt_state = ST_FALL;
            end
            ST_FALL: begin
                if (!enable)                               nxt_state = ST_IDLE;
                else if (step_evt && (duty_dn <= cfg_min)) nxt_state = ST_RISE;
            end
            ST_HOLD: begin
                if (!enable) nxt_state = ST_IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt_state;
    end

    // duty register (output of the sequencer)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            duty <= '0;
        end else begin
            unique case (state)
                ST_IDLE: duty <= cfg_min;
                ST_RISE: if (enable && step_evt) duty <= duty_up;
                ST_FALL: if (enable && step_evt) duty <= duty_dn;
                ST_HOLD: duty <= cfg_min;
            endcase
        end
    end

    // R4: the ramp starts from the minimum
    p_enter_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && enable) |=> (duty == $past(cfg_min)));

    // R4: the duty level is unchanged between step events while ramping
    p_duty_steady_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (running && state != ST_HOLD && !step_evt) |=> $stable(duty));

    // R5: each step moves the duty by exactly one
    p_unit_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (running && state != ST_HOLD && step_evt) |=>
            (duty == $past(duty) + ONE_L || duty == $past(duty) - ONE_L));

    // R6: the hold state pins the duty at the minimum
    p_hold_min_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && enable) |=> (duty == $past(cfg_min)));
endmodule

// File: rtl/breath_out.sv
// Compare stage: active while the sub-counter is below the duty, then polarity.
module breath_out
    import breath_pkg::*;
#(
    parameter int LEVEL_W = 8
) (
    input  breath_state_t      state,
    input  logic [LEVEL_W-1:0] cnt,
    input  logic [LEVEL_W-1:0] duty,
    input  logic               invert,
    output logic               pwm
);
    logic active;

    always_comb begin
        active = (state != ST_IDLE) && (cnt < duty);
        pwm    = active ^ invert;
    end
endmodule

// File: rtl/breath_pwm.sv
module breath_pwm
    import breath_pkg::*;
#(
    parameter int LEVEL_W = 8,
    parameter int STEP_W  = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               breath_en,
    input  logic               invert_out,
    input  logic [LEVEL_W-1:0] div_cfg,
    input  logic [STEP_W-1:0]  step_cfg,
    input  logic [LEVEL_W-1:0] duty_hi,
    input  logic [LEVEL_W-1:0] duty_lo,
    output logic               pwm_out
);
    breath_state_t      state;
    logic [LEVEL_W-1:0] duty;
    logic [LEVEL_W-1:0] cnt;
    logic               running;
    logic               step_evt;

    breath_seq #(.LEVEL_W(LEVEL_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (breath_en),
        .step_evt (step_evt),
        .cfg_min  (duty_lo),
        .cfg_max  (duty_hi),
        .state    (state),
        .duty     (duty),
        .running  (running)
    );

    breath_timer #(.LEVEL_W(LEVEL_W), .STEP_W(STEP_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (running),
        .cfg_div  (div_cfg),
        .cfg_step (step_cfg),
        .cnt      (cnt),
        .step_evt (step_evt)
    );

    breath_out #(.LEVEL_W(LEVEL_W)) u_out (
        .state  (state),
        .cnt    (cnt),
        .duty   (duty),
        .invert (invert_out),
        .pwm    (pwm_out)
    );

    // R1: one edge after the enable drops, the output shows the inactive level
    p_idle_level_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!breath_en) |=> (pwm_out == invert_out));
endmodule

// File: tb/sim_breath_pwm.sv
module sim_breath_pwm;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        breath_en = 1'b0;
    logic        invert_out = 1'b0;
    logic [7:0]  div_cfg = 8'd0;
    logic [15:0] step_cfg = 16'd0;
    logic [7:0]  duty_hi = 8'd0;
    logic [7:0]  duty_lo = 8'd0;
    logic        pwm_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    breath_pwm u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .breath_en  (breath_en),
        .invert_out (invert_out),
        .div_cfg    (div_cfg),
        .step_cfg   (step_cfg),
        .duty_hi    (duty_hi),
        .duty_lo    (duty_lo),
        .pwm_out    (pwm_out)
    );

    // triangle-wave model from the cycle index since enable
    function automatic logic model(int t, int dv, int st, int mn, int mx, int pol);
        int c, per, k, d, span, m;
        c   = t % (dv + 1);
        per = t / (dv + 1);
        k   = per / (st + 1);
        if (mn >= mx) d = mn;
        else begin
            span = mx - mn;
            m    = k % (2 * span);
            d    = (m <= span) ? mn + m : mn + 2 * span - m;
        end
        return logic'((c < d) ? 1 : 0) ^ logic'(pol);
    endfunction

    task automatic check(string tag, logic got, logic exp, int t);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s t=%0d div=%0d step=%0d lo=%0d hi=%0d inv=%0d: got %b expected %b",
                     tag, t, div_cfg, step_cfg, duty_lo, duty_hi, invert_out, got, exp);
        end
    endtask

    initial begin
        int divs[3]  = '{0, 1, 3};
        int steps[2] = '{0, 2};
        // reset state, both polarities (R1, R7)
        #(CLK_PERIOD * 2);
        check("R1", pwm_out, 1'b0, 0);
        invert_out = 1'b1;
        #1;
        check("R1 R7", pwm_out, 1'b1, 0);
        @(negedge clk);
        rst_n = 1'b1;
        for (int p = 0; p < 2; p++) begin
            for (int di = 0; di < 3; di++) begin
                for (int si = 0; si < 2; si++) begin
                    for (int mn = 0; mn < 4; mn++) begin
                        for (int mx = 0; mx < 5; mx++) begin
                            int dv, st, span, ncyc;
                            string tag;
                            dv = divs[di];
                            st = steps[si];
                            @(negedge clk);
                            invert_out = logic'(p);
                            div_cfg    = 8'(dv);
                            step_cfg   = 16'(st);
                            duty_lo    = 8'(mn);
                            duty_hi    = 8'(mx);
                            span = (mn < mx) ? mx - mn : 1;
                            ncyc = 2 * span * (st + 1) * (dv + 1) + 2 * (dv + 1);
                            if (ncyc > 150) ncyc = 150;
                            if (mn >= mx)   tag = "R6 R2 R3 R4";
                            else if (p == 1) tag = "R7 R5 R9 R3";
                            else            tag = "R5 R9 R2 R3 R4";
                            // idle level before enable (R1)
                            #1;
                            check("R1", pwm_out, logic'(p), -1);
                            @(negedge clk);
                            breath_en = 1'b1;
                            for (int t = 0; t < ncyc; t++) begin
                                @(posedge clk);
                                #2;
                                check(tag, pwm_out, model(t, dv, st, mn, mx, p), t);
                            end
                            // disable: inactive level, counters cleared (R1, R8)
                            @(negedge clk);
                            breath_en = 1'b0;
                            for (int t = 0; t < 2; t++) begin
                                @(posedge clk);
                                #2;
                                check("R1 R8", pwm_out, logic'(p), t);
                            end
                        end
                    end
                end
            end
        end
        // re-enable restarts from the minimum (R8)
        @(negedge clk);
        invert_out = 1'b0; div_cfg = 8'd3; step_cfg = 16'd0; duty_lo = 8'd1; duty_hi = 8'd3;
        breath_en = 1'b1;
        repeat (6) @(negedge clk);
        breath_en = 1'b0;
        @(negedge clk);
        breath_en = 1'b1;
        for (int t = 0; t < 16; t++) begin
            @(posedge clk);
            #2;
            check("R8 R4", pwm_out, model(t, 3, 0, 1, 3, 0), t);
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule